// File: doc/BRIEF.md
# PLL reference selector and monitor

This block prepares the timing reference for the digital phase-locked loop of a TDM switch. One of two sources is chosen: an external reference pin, or an internal 8 kHz reference built from the frame clock and frame pulse inputs. The external reference can be inverted. Both sources are brought into the system clock domain, and a single-cycle strobe marks every rising edge of the chosen reference while the loop runs locked to it.

The block measures every reference period in system clock cycles and compares it with a window around the nominal count for the programmed rate. Hysteresis turns the result into a validity flag. Validity is lost on repeated out-of-window periods or on a missing reference. The block also decodes two control bits into the loop's operating mode: locked to the reference, free-running, or bypassed.

Nominal counts per rate are parameters, sized for the system clock in use. The period tolerance and the hysteresis counts are also parameters.

Top module: `pll_ref_guard`

## Requirements
- R1: Out of reset, ref_valid_o is 0, ref_edge_o is 0 and loop_mode_o is 0 (locked mode).
- R2: loop_mode_o takes its new value one clock after the control bits change. bypass_bit_i = 1 gives 2 (bypass), whatever freerun_bit_i holds. Otherwise freerun_bit_i = 0 gives 0 (locked) and freerun_bit_i = 1 gives 1 (free-running).
- R3: In locked mode, each rising edge of the external reference gives exactly one one-cycle ref_edge_o pulse. The pulse is seen three clock cycles after the input changes: two synchronizer flops, then a registered edge strobe.
- R4: With ref_inv_i = 1 the external reference is inverted before edge detection, so pulses follow its falling edges with the same three-cycle latency.
- R5: ref_edge_o stays 0 while loop_mode_o is 1 or 2.
- R6: With src_int_i = 1, the reference edge is the frame pulse value sampled at each rising edge of the frame clock. In this case the 8 kHz window is used whatever rate_sel_i holds.
- R7: rate_sel_i = 00, 01 and 10 select the 8 kHz, 1.544 MHz and 2.048 MHz nominal counts. A period is in window when it lies within nominal ± (nominal >> 4), bounds included.
- R8: While invalid, ref_valid_o rises after four consecutive in-window periods, and not after three.
- R9: ref_valid_o falls after two consecutive out-of-window periods. A single out-of-window period between in-window ones leaves it set.
- R10: ref_valid_o falls when no reference edge arrives for twice the nominal period. It stays set for a gap just below that.
- R11: rate_sel_i = 11 with the external source holds ref_valid_o at 0 from the next clock, whatever the reference does.
- R12: The validity flag keeps updating in bypass and free-running modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_ref_i | input | 1 | External reference, asynchronous |
| frm_clk_i | input | 1 | Frame clock for the internal reference, asynchronous |
| frm_pulse_i | input | 1 | Frame pulse for the internal reference, asynchronous |
| src_int_i | input | 1 | 1 selects the internal 8 kHz reference |
| ref_inv_i | input | 1 | 1 inverts the external reference |
| rate_sel_i | input | 2 | Nominal rate: 00 8 kHz, 01 1.544 MHz, 10 2.048 MHz, 11 reserved |
| bypass_bit_i | input | 1 | Bypass control bit, wins over freerun_bit_i |
| freerun_bit_i | input | 1 | Free-running control bit |
| ref_edge_o | output | 1 | One-cycle strobe per reference rising edge in locked mode |
| ref_valid_o | output | 1 | Reference period within window |
| loop_mode_o | output | 2 | 0 locked, 1 free-running, 2 bypass |

## Verification
Two things can happen in the same cycle: the period check at a reference edge, and expiry of the missing-edge timer or a change of the rate window. The random trials provoke this by switching rate_sel_i while the reference keeps running. The first edge after a switch is then measured against the new window, and when the new rate is faster, the timer of that rate may already have run out. The bench requires validity at the end of six nominal periods at the new rate. It then computes whether a random period offset keeps or drops validity from the stated window bounds alone.

// File: rtl/pll_ref_pkg.sv
package pll_ref_pkg;

  typedef enum logic [1:0] {
    MODE_LOCKED = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_BYPASS = 2'd2
  } loop_mode_e;

  localparam logic [1:0] RATE_8K  = 2'd0;
  localparam logic [1:0] RATE_T1  = 2'd1;
  localparam logic [1:0] RATE_E1  = 2'd2;
  localparam logic [1:0] RATE_RSV = 2'd3;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ref_sync.sv
module ref_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/ref_edge.sv
module ref_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic fclk_i,
  input  logic fp_i,
  input  logic src_int_i,
  input  logic inv_i,
  input  logic en_i,
  output logic rise_o,
  output logic pulse_o
);

  logic ext_s, fclk_s, fp_s;
  logic fclk_d, int_lvl_q, lvl, lvl_d, pulse_q;

  ref_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ext_i, fclk_i, fp_i}),
    .q_o    ({ext_s, fclk_s, fp_s})
  );

  // internal 8 kHz level: frame pulse captured at frame clock rise
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      fclk_d    <= 1'b0;
      int_lvl_q <= 1'b0;
    end else begin
      fclk_d <= fclk_s;
      if (fclk_s && !fclk_d) int_lvl_q <= fp_s;
    end

  assign lvl    = src_int_i ? int_lvl_q : (ext_s ^ inv_i);
  assign rise_o = lvl && !lvl_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lvl_d   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      lvl_d   <= lvl;
      pulse_q <= rise_o && en_i;
    end

  assign pulse_o = pulse_q;

  a_r3_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  a_r3_pulse_from_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(rise_o));

endmodule

// File: rtl/period_mon.sv
module period_mon
  import pll_ref_pkg::*;
#(
  parameter int NOM_8K    = 15625,
  parameter int NOM_T1    = 81,
  parameter int NOM_E1    = 61,
  parameter int TOL_SHIFT = 4,
  parameter int GOOD_N    = 4,
  parameter int BAD_N     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       src_int_i,
  input  logic [1:0] rate_i,
  output logic       valid_o
);

  localparam int NOM_MAX = max3(NOM_8K, NOM_T1, NOM_E1);
  localparam int CW = $clog2(2 * NOM_MAX + 1);
  localparam int GW = $clog2(GOOD_N + 1);
  localparam int BW = $clog2(BAD_N + 1);
  localparam logic [GW-1:0] GOOD_MAX = GW'(GOOD_N);
  localparam logic [BW-1:0] BAD_MAX  = BW'(BAD_N);

  logic [1:0]    rate_eff;
  logic [CW-1:0] nom, tol, lo, hi, lim, period, cnt_q;
  logic          tmo, in_win, have_q, valid_q;
  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;

  always_comb begin
    rate_eff = src_int_i ? RATE_8K : rate_i;
    case (rate_eff)
      RATE_T1: nom = CW'(NOM_T1);
      RATE_E1: nom = CW'(NOM_E1);
      default: nom = CW'(NOM_8K);
    endcase
  end

  assign tol    = nom >> TOL_SHIFT;
  assign lo     = nom - tol;
  assign hi     = nom + tol;
  assign lim    = (nom << 1) - CW'(1);
  assign period = cnt_q + CW'(1);
  assign tmo    = cnt_q >= lim;
  assign in_win = (period >= lo) && (period <= hi);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q   <= '0;
      have_q  <= 1'b0;
      good_q  <= '0;
      bad_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (rise_i)    cnt_q <= '0;
      else if (!tmo) cnt_q <= period;

      if (rise_i)   have_q <= 1'b1;
      else if (tmo) have_q <= 1'b0;

      if (rate_eff == RATE_RSV) begin
        valid_q <= 1'b0;
        good_q  <= '0;
        bad_q   <= '0;
      end else if (rise_i && have_q) begin
        if (in_win) begin
          bad_q <= '0;
          if (good_q != GOOD_MAX) good_q <= good_q + GW'(1);
          if (good_q >= GOOD_MAX - GW'(1)) valid_q <= 1'b1;
        end else begin
          good_q <= '0;
          if (bad_q != BAD_MAX) bad_q <= bad_q + BW'(1);
          if (bad_q >= BAD_MAX - BW'(1)) valid_q <= 1'b0;
        end
      end else if (tmo && !rise_i) begin
        valid_q <= 1'b0;
        good_q  <= '0;
        bad_q   <= '0;
      end
    end

  assign valid_o = valid_q;

  a_r11_reserved_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_eff == RATE_RSV) |=> !valid_o);

  a_r10_gap_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo && !rise_i) |=> !valid_o);

  a_r8_gain_at_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(rise_i));

  a_r9_loss_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> $past(rise_i || tmo || rate_eff == RATE_RSV));

endmodule

// File: rtl/mode_dec.sv
module mode_dec
  import pll_ref_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bypass_i,
  input  logic       free_i,
  output loop_mode_e mode_o
);

  loop_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       mode_q <= MODE_LOCKED;
    else if (bypass_i) mode_q <= MODE_BYPASS;
    else if (free_i)   mode_q <= MODE_FREE;
    else               mode_q <= MODE_LOCKED;

  assign mode_o = mode_q;

  a_r2_bypass_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> (mode_o == MODE_BYPASS));

  a_r2_free_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && free_i) |=> (mode_o == MODE_FREE));

  a_r2_locked_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && !free_i) |=> (mode_o == MODE_LOCKED));

endmodule

// File: rtl/pll_ref_guard.sv
module pll_ref_guard
  import pll_ref_pkg::*;
#(
  parameter int NOM_8K      = 15625,
  parameter int NOM_T1      = 81,
  parameter int NOM_E1      = 61,
  parameter int TOL_SHIFT   = 4,
  parameter int GOOD_N      = 4,
  parameter int BAD_N       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_ref_i,
  input  logic       frm_clk_i,
  input  logic       frm_pulse_i,
  input  logic       src_int_i,
  input  logic       ref_inv_i,
  input  logic [1:0] rate_sel_i,
  input  logic       bypass_bit_i,
  input  logic       freerun_bit_i,
  output logic       ref_edge_o,
  output logic       ref_valid_o,
  output logic [1:0] loop_mode_o
);

  loop_mode_e mode;
  logic       rise;

  mode_dec u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass_bit_i),
    .free_i   (freerun_bit_i),
    .mode_o   (mode)
  );

  ref_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_i     (ext_ref_i),
    .fclk_i    (frm_clk_i),
    .fp_i      (frm_pulse_i),
    .src_int_i (src_int_i),
    .inv_i     (ref_inv_i),
    .en_i      (mode == MODE_LOCKED),
    .rise_o    (rise),
    .pulse_o   (ref_edge_o)
  );

  period_mon #(
    .NOM_8K    (NOM_8K),
    .NOM_T1    (NOM_T1),
    .NOM_E1    (NOM_E1),
    .TOL_SHIFT (TOL_SHIFT),
    .GOOD_N    (GOOD_N),
    .BAD_N     (BAD_N)
  ) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .src_int_i (src_int_i),
    .rate_i    (rate_sel_i),
    .valid_o   (ref_valid_o)
  );

  assign loop_mode_o = mode;

  a_r5_quiet_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_mode_o != MODE_LOCKED) |=> !ref_edge_o);

endmodule

// File: tb/sim_pll_ref_guard.sv
module sim_pll_ref_guard;

  localparam int P8 = 320;
  localparam int PT = 81;
  localparam int PE = 61;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_ref = 1'b0, frm_clk = 1'b0, frm_pulse = 1'b0;
  logic       src_int = 1'b0, ref_inv = 1'b0, byp = 1'b0, frb = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       ref_edge, ref_valid;
  logic [1:0] loop_mode;

  int checks = 0, fails = 0;
  int cyc = 0, kk = 0;
  int pulse_cnt = 0, last_pulse = 0, rise_cyc = 0, fall_cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pll_ref_guard #(.NOM_8K(P8), .NOM_T1(PT), .NOM_E1(PE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ext_ref_i(ext_ref), .frm_clk_i(frm_clk),
    .frm_pulse_i(frm_pulse), .src_int_i(src_int), .ref_inv_i(ref_inv),
    .rate_sel_i(rate_sel), .bypass_bit_i(byp), .freerun_bit_i(frb),
    .ref_edge_o(ref_edge), .ref_valid_o(ref_valid), .loop_mode_o(loop_mode)
  );

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (ref_edge) begin
      pulse_cnt++;
      last_pulse = cyc;
    end
    kk++;
    frm_clk   = (kk % 8) < 4;
    frm_pulse = ((kk % P8) >= P8 - 4) || ((kk % P8) < 4);
  end

  function automatic int nom_of(input int r);
    case (r)
      1: return PT;
      2: return PE;
      default: return P8;
    endcase
  endfunction

  function automatic int in_win(input int p, input int nom);
    return (p >= nom - (nom >> 4)) && (p <= nom + (nom >> 4));
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_ref(input int per, input int n);
    for (int i = 0; i < n; i++) begin
      ext_ref = 1'b1;
      rise_cyc = cyc;
      tick(per / 2);
      ext_ref = 1'b0;
      fall_cyc = cyc;
      tick(per - per / 2);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int p0, r, nom, tol, off, p;
    void'($urandom(32'd1234));
    tick(3);
    chk("R1 valid in reset", int'(ref_valid), 0);
    chk("R1 mode in reset", int'(loop_mode), 0);
    rst_ni = 1'b1;
    tick(2);
    chk("R1 valid after reset", int'(ref_valid), 0);
    chk("R1 edge after reset", int'(ref_edge), 0);
    chk("R1 mode after reset", int'(loop_mode), 0);

    // R2 mode decode
    frb = 1; tick(1); chk("R2 freerun", int'(loop_mode), 1);
    byp = 1; tick(1); chk("R2 bypass over freerun", int'(loop_mode), 2);
    frb = 0; tick(1); chk("R2 bypass", int'(loop_mode), 2);
    byp = 0; tick(1); chk("R2 locked", int'(loop_mode), 0);

    // R3 and R7 at 1.544 MHz
    rate_sel = 2'd1;
    tick(2);
    p0 = pulse_cnt;
    run_ref(PT, 6);
    chk("R3 pulse count", pulse_cnt - p0, 6);
    chk("R3 pulse latency", last_pulse - rise_cyc, 3);
    chk("R7 nominal valid", int'(ref_valid), 1);

    // R4 inversion
    ref_inv = 1'b1;
    tick(5);
    run_ref(PT, 1);
    chk("R4 pulse on falling edge", last_pulse - fall_cyc, 3);
    ref_inv = 1'b0;
    tick(5);

    // R10 gap then R8 regain
    tick(2 * PT + 5);
    chk("R10 gap loss", int'(ref_valid), 0);
    run_ref(PT, 4);
    chk("R8 three periods not enough", int'(ref_valid), 0);
    run_ref(PT, 1);
    chk("R8 four periods regain", int'(ref_valid), 1);
    tick(PT - 10);
    chk("R10 short gap keeps valid", int'(ref_valid), 1);
    tick(20);
    chk("R10 long gap drops valid", int'(ref_valid), 0);

    // R9 hysteresis on loss
    run_ref(PT, 6);
    chk("R9 baseline valid", int'(ref_valid), 1);
    run_ref(PT + 10, 1);
    run_ref(PT, 3);
    chk("R9 single bad period ignored", int'(ref_valid), 1);
    run_ref(PT + 10, 2);
    run_ref(PT, 1);
    chk("R9 two bad periods drop", int'(ref_valid), 0);

    // R7 window bounds
    run_ref(PT, 6);
    run_ref(PT + 5, 4);
    run_ref(PT - 5, 4);
    run_ref(PT, 1);
    chk("R7 bounds inside window", int'(ref_valid), 1);
    run_ref(PT + 6, 2);
    run_ref(PT, 1);
    chk("R7 just outside window", int'(ref_valid), 0);

    // R11 reserved rate
    run_ref(PT, 6);
    chk("R11 baseline valid", int'(ref_valid), 1);
    rate_sel = 2'd3;
    tick(1);
    chk("R11 reserved drops next clock", int'(ref_valid), 0);
    run_ref(PT, 6);
    chk("R11 reserved stays invalid", int'(ref_valid), 0);

    // R5 and R12 in bypass and freerun
    rate_sel = 2'd1;
    byp = 1;
    tick(2);
    p0 = pulse_cnt;
    run_ref(PT, 6);
    chk("R5 no pulse in bypass", pulse_cnt - p0, 0);
    chk("R12 valid updates in bypass", int'(ref_valid), 1);
    byp = 0; frb = 1;
    tick(2);
    p0 = pulse_cnt;
    tick(2 * PT + 5);
    chk("R12 gap loss in freerun", int'(ref_valid), 0);
    run_ref(PT, 6);
    chk("R5 no pulse in freerun", pulse_cnt - p0, 0);
    chk("R12 valid updates in freerun", int'(ref_valid), 1);
    frb = 0;
    tick(2);

    // R6 internal source, rate field ignored
    src_int = 1'b1;
    p0 = pulse_cnt;
    tick(6 * P8 + 50);
    chk("R6 internal source valid", int'(ref_valid), 1);
    chk("R6 internal pulses seen", int'(pulse_cnt - p0 >= 5), 1);
    src_int = 1'b0;
    tick(3 * P8);
    chk("R6 external idle invalid", int'(ref_valid), 0);

    // R7 random periods across rates
    for (int t = 0; t < 12; t++) begin
      r = int'($urandom_range(2, 0));
      rate_sel = 2'(r);
      nom = nom_of(r);
      tol = nom >> 4;
      run_ref(nom, 6);
      chk("R7 random nominal valid", int'(ref_valid), 1);
      off = int'($urandom_range(2 * tol + 4, 0)) - (tol + 2);
      p = nom + off;
      run_ref(p, 3);
      chk("R7 random offset window", int'(ref_valid), in_win(p, nom));
    end

    finish_run();
  end

endmodule